// File: doc/BRIEF.md
# Master-side bus requester with selectable release policy

This block sits between a module's local master logic and a shared backplane bus. When the local side asks for a bus cycle, the block raises one of four request lines and waits for the matching grant. Once the grant arrives and the backplane is not busy, it takes ownership by driving bus-busy and tells the local cycle logic that it may run its transfer.

After the transfer, a configurable release policy decides whether bus-busy is dropped at once or held. While the bus is held, the block is parked. A parked block serves further local requests without arbitrating again.

The block also guards two hazards:
- **Deadlock.** A local request made while a slave access to this module is still running is refused and flagged, so that the local side can retry later.
- **Self-access.** A slave select seen while this module holds the bus raises both a backplane bus error and a local bus error.

An optional fair mode stops the block from requesting while another board already requests on the same level.

Top module: `vme_requester`

## Requirements
- R1: While reset is low, and in the first cycle after it with idle inputs, every output is low.
- R2: A local request seen at a clock edge in the idle state raises `bus_req` one cycle later. Only bit `cfg_level` is set (bit i is level i), and it stays up until the grant is taken.
- R3: While requesting, the grant is taken at the first edge where `bus_grant[level]` is high and `bbsy_in` is low. One cycle later `bus_req` is low, and `bbsy_out` and `owned` are high. A grant seen while `bbsy_in` is high leaves the request waiting.
- R4: `cfg_mode` 1 is release when done. Codes 5 to 7 act the same. The cycle after `loc_done` is seen while owning, `bbsy_out` and `owned` are low.
- R5: `cfg_mode` 0 is release on request. After `loc_done` the block parks: `bbsy_out` is high and `owned` is low. It releases one cycle after any bit of `others_req` is seen.
- R6: `cfg_mode` 2 is release on clear. The block parks after `loc_done`, ignores `others_req`, and releases one cycle after `bclr` is seen.
- R7: `cfg_mode` 3 is lock control. If `loc_lock` is high at `loc_done`, the block parks and releases one cycle after `loc_lock` is seen low. Without the lock it releases like mode 1.
- R8: `cfg_mode` 4 is capture and hold. The block parks after `loc_done`, ignores `bclr` and `others_req`, and releases one cycle after `cfg_hold` is seen low.
- R9: A local request while parked and not releasing gives `owned` high one cycle later, without any `bus_req`.
- R10: With `cfg_fair` high, no request is raised while `others_req[cfg_level]` is high. Requests on other levels do not block. The request rises one cycle after the blocking bit clears.
- R11: A local request seen while `slv_busy` is high, in the idle or requesting state, sets `deadlock` one cycle later. It also leaves `bus_req` low. The request proceeds once `slv_busy` falls.
- R12: `slv_sel` seen while `bbsy_out` is high raises `berr_out` and `lberr` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_level | input | 2 | request level to use |
| cfg_mode | input | 3 | release policy code |
| cfg_fair | input | 1 | fair-request enable |
| cfg_hold | input | 1 | capture bit for mode 4 |
| loc_req | input | 1 | local master wants a cycle; held until loc_done |
| loc_done | input | 1 | local cycle finished (pulse) |
| loc_lock | input | 1 | indivisible-sequence lock |
| slv_busy | input | 1 | slave access to this module in progress |
| slv_sel | input | 1 | this module is selected as slave |
| others_req | input | 4 | request lines driven by other boards |
| bus_grant | input | 4 | grant-in lines, one per level |
| bbsy_in | input | 1 | bus busy driven by another master |
| bclr | input | 1 | bus clear from the arbiter |
| bus_req | output | 4 | request lines, one-hot |
| bbsy_out | output | 1 | this module holds the bus |
| owned | output | 1 | local cycle may run |
| deadlock | output | 1 | request refused, retry later |
| berr_out | output | 1 | backplane bus error on self-access |
| lberr | output | 1 | local bus error on self-access |

## Verification
The bench parks the block under each release policy. It then presents the stimuli that must not release it: `bclr` in capture mode, and other requests in clear mode. A block that decoded the mode wrongly would drop bus-busy early or hold it forever.

The bench also checks three boundaries:
- It offers a grant while `bbsy_in` is still high. A design that ignored `bbsy_in` would drive busy over another master.
- It blocks a fair request only on its own level. A wrong index would stall the request, or raise it too early.
- It asserts a slave select during ownership and a slave-busy during a request. A design that missed either hazard would hang the bus or miss the error.

// File: rtl/vme_req_pkg.sv
package vme_req_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2,
        ST_PARK = 2'd3
    } req_state_e;

    typedef enum logic [2:0] {
        REL_ON_REQ  = 3'd0,
        REL_DONE    = 3'd1,
        REL_ON_CLR  = 3'd2,
        REL_LOCK    = 3'd3,
        REL_CAPTURE = 3'd4
    } rel_mode_e;

endpackage

// File: rtl/vme_req_fair_gate.sv
module vme_req_fair_gate #(
    parameter int NLVL = 4,
    localparam int LW = $clog2(NLVL)
) (
    input  logic            fair_en,
    input  logic [LW-1:0]   level,
    input  logic [NLVL-1:0] others_req,
    output logic            may_req
);
    // Only a request on our own level holds us back.
    always_comb begin
        may_req = !(fair_en && others_req[level]);
    end
endmodule

// File: rtl/vme_req_release.sv
module vme_req_release #(
    parameter int NLVL = 4
) (
    input  logic [2:0]      mode,
    input  logic [NLVL-1:0] others_req,
    input  logic            bclr,
    input  logic            lock,
    input  logic            hold,
    output logic            park_at_done,
    output logic            release_ok
);
    import vme_req_pkg::*;

    always_comb begin
        park_at_done = 1'b0;
        release_ok   = 1'b1;
        case (mode)
            REL_ON_REQ: begin
                park_at_done = 1'b1;
                release_ok   = |others_req;
            end
            REL_ON_CLR: begin
                park_at_done = 1'b1;
                release_ok   = bclr;
            end
            REL_LOCK: begin
                park_at_done = lock;
                release_ok   = !lock;
            end
            REL_CAPTURE: begin
                park_at_done = 1'b1;
                release_ok   = !hold;
            end
            default: begin
                park_at_done = 1'b0;
                release_ok   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vme_req_level_dec.sv
module vme_req_level_dec #(
    parameter int NLVL = 4,
    localparam int LW = $clog2(NLVL)
) (
    input  logic            en,
    input  logic [LW-1:0]   level,
    output logic [NLVL-1:0] lines
);
    for (genvar i = 0; i < NLVL; i++) begin : g_line
        assign lines[i] = en && (level == LW'(i));
    end
endmodule

// File: rtl/vme_requester.sv
module vme_requester #(
    parameter int NLVL = 4,
    localparam int LW = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   cfg_level,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_fair,
    input  logic            cfg_hold,
    input  logic            loc_req,
    input  logic            loc_done,
    input  logic            loc_lock,
    input  logic            slv_busy,
    input  logic            slv_sel,
    input  logic [NLVL-1:0] others_req,
    input  logic [NLVL-1:0] bus_grant,
    input  logic            bbsy_in,
    input  logic            bclr,
    output logic [NLVL-1:0] bus_req,
    output logic            bbsy_out,
    output logic            owned,
    output logic            deadlock,
    output logic            berr_out,
    output logic            lberr
);
    import vme_req_pkg::*;

    typedef struct packed {
        req_state_e  st;
        logic [LW-1:0] lvl;
        logic        dead;
        logic        berr;
    } req_regs_t;

    req_regs_t r_q, r_d;
    logic may_req, park_at_done, release_ok, holding;

    vme_req_fair_gate #(.NLVL(NLVL)) u_fair (
        .fair_en   (cfg_fair),
        .level     (cfg_level),
        .others_req(others_req),
        .may_req   (may_req)
    );

    vme_req_release #(.NLVL(NLVL)) u_rel (
        .mode        (cfg_mode),
        .others_req  (others_req),
        .bclr        (bclr),
        .lock        (loc_lock),
        .hold        (cfg_hold),
        .park_at_done(park_at_done),
        .release_ok  (release_ok)
    );

    vme_req_level_dec #(.NLVL(NLVL)) u_dec (
        .en   (r_q.st == ST_REQ),
        .level(r_q.lvl),
        .lines(bus_req)
    );

    assign holding = (r_q.st == ST_OWN) || (r_q.st == ST_PARK);

    always_comb begin
        r_d      = r_q;
        r_d.dead = 1'b0;
        r_d.berr = holding && slv_sel;
        case (r_q.st)
            ST_IDLE: begin
                if (loc_req) begin
                    if (slv_busy) begin
                        r_d.dead = 1'b1;
                    end else if (may_req) begin
                        r_d.st  = ST_REQ;
                        r_d.lvl = cfg_level;
                    end
                end
            end
            ST_REQ: begin
                if (loc_req && slv_busy) begin
                    r_d.dead = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (bus_grant[r_q.lvl] && !bbsy_in) begin
                    r_d.st = ST_OWN;
                end
            end
            ST_OWN: begin
                if (loc_done) begin
                    r_d.st = park_at_done ? ST_PARK : ST_IDLE;
                end
            end
            ST_PARK: begin
                if (release_ok) begin
                    r_d.st = ST_IDLE;
                end else if (loc_req) begin
                    r_d.st = ST_OWN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, lvl: '0, dead: 1'b0, berr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bbsy_out = holding;
    assign owned    = (r_q.st == ST_OWN);
    assign deadlock = r_q.dead;
    assign berr_out = r_q.berr;
    assign lberr    = r_q.berr;

    // R2: never more than one level requested at once
    a_r2_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_req));

    // R3: requesting and holding never overlap
    a_r3_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !((|bus_req) && bbsy_out));

    // R3: a clean grant leads to ownership
    a_r3_take_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bus_req) && |(bus_grant & bus_req) && !bbsy_in && !(loc_req && slv_busy))
        |=> (owned && bbsy_out));

    // R4: release when done frees the bus right after the cycle
    a_r4_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == REL_DONE && owned && loc_done) |=> !bbsy_out);

    // R8: capture keeps the bus while the hold bit is set
    a_r8_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == REL_CAPTURE && cfg_hold && bbsy_out) |=> bbsy_out);

    // R9: parked reuse needs no arbitration
    a_r9_park_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (bbsy_out && !owned && loc_req && !release_ok) |=> (owned && bus_req == '0));

    // R10: fair mode never requests over a pending request on our level
    a_r10_fair_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fair && !bbsy_out && bus_req == '0 && others_req[cfg_level]) |=> bus_req == '0);

    // R11: a flagged deadlock never comes with a request
    a_r11_dead_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |-> (bus_req == '0 && !bbsy_out));

    // R12: self-access while holding raises both errors
    a_r12_self_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bbsy_out && slv_sel) |=> (berr_out && lberr));

endmodule

// File: tb/vme_requester_test.sv
module vme_requester_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_level = '0;
    logic [2:0] cfg_mode = 3'd1;
    logic       cfg_fair = 1'b0, cfg_hold = 1'b0;
    logic       loc_req = 1'b0, loc_done = 1'b0, loc_lock = 1'b0;
    logic       slv_busy = 1'b0, slv_sel = 1'b0;
    logic [3:0] others_req = '0, bus_grant = '0;
    logic       bbsy_in = 1'b0, bclr = 1'b0;
    logic [3:0] bus_req;
    logic       bbsy_out, owned, deadlock, berr_out, lberr;

    vme_requester uut (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_mode(cfg_mode),
        .cfg_fair(cfg_fair), .cfg_hold(cfg_hold), .loc_req(loc_req),
        .loc_done(loc_done), .loc_lock(loc_lock), .slv_busy(slv_busy),
        .slv_sel(slv_sel), .others_req(others_req), .bus_grant(bus_grant),
        .bbsy_in(bbsy_in), .bclr(bclr), .bus_req(bus_req), .bbsy_out(bbsy_out),
        .owned(owned), .deadlock(deadlock), .berr_out(berr_out), .lberr(lberr)
    );

    always #5 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [8:0] exp;
        string      tag;
    } item_t;

    item_t queue_q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] ov(logic [3:0] r, logic b, logic o, logic d, logic e);
        return {r, b, o, d, e, e};
    endfunction

    // monitor: compares each expected item in its cycle
    always @(negedge clk) begin
        while (queue_q.size() > 0 && queue_q[0].cyc <= cyc) begin
            item_t it;
            logic [8:0] got;
            it = queue_q.pop_front();
            got = {bus_req, bbsy_out, owned, deadlock, berr_out, lberr};
            checks++;
            if (it.cyc != cyc || got !== it.exp) begin
                fails++;
                $display("FAIL %s: got %b expected %b (cycle %0d)", it.tag, got, it.exp, cyc);
            end
        end
    end

    // driver: expect a result one cycle after the current inputs
    task automatic chk(input string tag, input logic [8:0] e);
        item_t it;
        it.cyc = cyc + 1;
        it.exp = e;
        it.tag = tag;
        queue_q.push_back(it);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done_flag) begin
            done_flag = 1'b1;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R1 in reset", ov(4'b0000, 0, 0, 0, 0));
        chk("R1 in reset", ov(4'b0000, 0, 0, 0, 0));
        rst_n = 1'b1;
        chk("R1 after reset", ov(4'b0000, 0, 0, 0, 0));

        // release when done, level 2
        cfg_mode = 3'd1; cfg_level = 2'd2;
        loc_req = 1;
        chk("R2 request lvl2", ov(4'b0100, 0, 0, 0, 0));
        chk("R2 request held", ov(4'b0100, 0, 0, 0, 0));
        bus_grant = 4'b0100; bbsy_in = 1;
        chk("R3 wait bbsy_in", ov(4'b0100, 0, 0, 0, 0));
        bbsy_in = 0;
        chk("R3 take grant", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0;
        chk("R3 keep owning", ov(4'b0000, 1, 1, 0, 0));
        slv_sel = 1;
        chk("R12 self access", ov(4'b0000, 1, 1, 0, 1));
        slv_sel = 0; loc_req = 0; loc_done = 1;
        chk("R4 drop after done", ov(4'b0000, 0, 0, 0, 0));
        loc_done = 0;
        chk("R4 stays idle", ov(4'b0000, 0, 0, 0, 0));

        // release on request, level 0
        cfg_mode = 3'd0; cfg_level = 2'd0;
        loc_req = 1;
        chk("R2 request lvl0", ov(4'b0001, 0, 0, 0, 0));
        bus_grant = 4'b0001;
        chk("R3 grant lvl0", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R5 park", ov(4'b0000, 1, 0, 0, 0));
        loc_done = 0;
        chk("R5 stay parked", ov(4'b0000, 1, 0, 0, 0));
        loc_req = 1;
        chk("R9 reuse parked", ov(4'b0000, 1, 1, 0, 0));
        loc_req = 0; loc_done = 1;
        chk("R5 park again", ov(4'b0000, 1, 0, 0, 0));
        loc_done = 0; others_req = 4'b0100;
        chk("R5 release on other", ov(4'b0000, 0, 0, 0, 0));
        others_req = 0;
        chk("R5 idle", ov(4'b0000, 0, 0, 0, 0));

        // release on clear, level 1
        cfg_mode = 3'd2; cfg_level = 2'd1;
        loc_req = 1;
        chk("R2 request lvl1", ov(4'b0010, 0, 0, 0, 0));
        bus_grant = 4'b0010;
        chk("R3 grant lvl1", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R6 park", ov(4'b0000, 1, 0, 0, 0));
        loc_done = 0; others_req = 4'b1111;
        chk("R6 others ignored", ov(4'b0000, 1, 0, 0, 0));
        others_req = 0; bclr = 1;
        chk("R6 release on clear", ov(4'b0000, 0, 0, 0, 0));
        bclr = 0;

        // lock control, level 3
        cfg_mode = 3'd3; cfg_level = 2'd3;
        loc_req = 1; loc_lock = 1;
        chk("R2 request lvl3", ov(4'b1000, 0, 0, 0, 0));
        bus_grant = 4'b1000;
        chk("R3 grant lvl3", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R7 park under lock", ov(4'b0000, 1, 0, 0, 0));
        loc_done = 0;
        chk("R7 held under lock", ov(4'b0000, 1, 0, 0, 0));
        loc_lock = 0;
        chk("R7 release on unlock", ov(4'b0000, 0, 0, 0, 0));
        loc_req = 1;
        chk("R7 request no lock", ov(4'b1000, 0, 0, 0, 0));
        bus_grant = 4'b1000;
        chk("R7 grant no lock", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R7 no lock drops", ov(4'b0000, 0, 0, 0, 0));
        loc_done = 0;

        // capture and hold, level 0
        cfg_mode = 3'd4; cfg_level = 2'd0; cfg_hold = 1;
        loc_req = 1;
        chk("R2 request cap", ov(4'b0001, 0, 0, 0, 0));
        bus_grant = 4'b0001;
        chk("R3 grant cap", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R8 park", ov(4'b0000, 1, 0, 0, 0));
        loc_done = 0; bclr = 1; others_req = 4'b1110;
        chk("R8 clear ignored", ov(4'b0000, 1, 0, 0, 0));
        bclr = 0; others_req = 0; cfg_hold = 0;
        chk("R8 release on hold clear", ov(4'b0000, 0, 0, 0, 0));

        // fair request, level 3
        cfg_mode = 3'd1; cfg_level = 2'd3; cfg_fair = 1;
        others_req = 4'b1000; loc_req = 1;
        chk("R10 blocked", ov(4'b0000, 0, 0, 0, 0));
        chk("R10 still blocked", ov(4'b0000, 0, 0, 0, 0));
        others_req = 4'b0100;
        chk("R10 other level free", ov(4'b1000, 0, 0, 0, 0));
        others_req = 0; bus_grant = 4'b1000;
        chk("R3 grant fair", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R4 release fair", ov(4'b0000, 0, 0, 0, 0));
        loc_done = 0; cfg_fair = 0;

        // deadlock, level 1
        cfg_level = 2'd1; slv_busy = 1; loc_req = 1;
        chk("R11 deadlock", ov(4'b0000, 0, 0, 1, 0));
        chk("R11 deadlock held", ov(4'b0000, 0, 0, 1, 0));
        slv_busy = 0;
        chk("R11 retry proceeds", ov(4'b0010, 0, 0, 0, 0));
        bus_grant = 4'b0010;
        chk("R3 grant after retry", ov(4'b0000, 1, 1, 0, 0));
        bus_grant = 0; loc_req = 0; loc_done = 1;
        chk("R4 final release", ov(4'b0000, 0, 0, 0, 0));
        loc_done = 0;

        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule